// File: doc/BRIEF.md
# Accumulator Execute Stage with Conditional Skip

This block is the execute stage of a small 8-bit accumulator machine. It holds one working register, a file of general registers (32 entries by default) and a zero flag. An operation code that has already been decoded selects one of four operations: clearing the working register, clearing a file register, inverting a file register, or testing one bit of a file register and skipping on a one. For the invert operation, a destination bit chooses where the result goes: the working register or the same file register.

When a bit test finds a one, the block raises `skipReq` for one cycle. The fetch stage uses this pulse to discard the instruction it fetched during the test. The block also protects itself. Any operation presented while `skipReq` is high runs as a no-op, so the squashed instruction changes nothing even if the fetch stage passes it through. A separate read port lets the surrounding pipeline, or a test, observe any file register combinationally.

Top module: `acc_exec`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the working register, every file register, the zero flag and `skipReq`.
- R2: Operation code 1 (clear working) sets `wOut` to 00h and the zero flag to 1 after the clock edge. The file is left unchanged.
- R3: Operation code 2 (clear file) writes 00h into the file register at `fileAddr` and sets the zero flag to 1. The working register is left unchanged.
- R4: Operation code 3 (invert) with `destSel` = 0 loads the bitwise inverse of the addressed file register into the working register. The file register keeps its value.
- R5: Operation code 3 with `destSel` = 1 writes the bitwise inverse back into the addressed file register. The working register keeps its value.
- R6: After operation code 3, the zero flag is 1 exactly when the 8-bit inverted result is 00h. Otherwise it is 0.
- R7: Operation code 4 (bit test) reads bit `bitIdx` of the addressed file register. If that bit is 1, `skipReq` is high during the following cycle only.
- R8: Operation code 4 on a bit that is 0 leaves `skipReq` low.
- R9: Any operation presented in a cycle where `skipReq` is high runs as a no-op. This holds even if that operation is a bit test: it changes no register and no flag, and it raises no skip.
- R10: Operation codes 0 (no-op) and 4 leave the working register, the file and the zero flag unchanged.
- R11: The unused codes 5, 6 and 7 behave as no-ops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opCode | input | 3 | Decoded operation: 0 no-op, 1 clear working, 2 clear file, 3 invert, 4 bit test |
| fileAddr | input | 5 | File register addressed by the operation |
| destSel | input | 1 | Invert destination: 0 working register, 1 file register |
| bitIdx | input | 3 | Bit tested by the bit-test operation |
| rdAddr | input | 5 | Address for the observation read port |
| rdData | output | 8 | Combinational contents of the file register at `rdAddr` |
| wOut | output | 8 | Working register |
| zeroFlag | output | 1 | Zero flag |
| skipReq | output | 1 | One-cycle request to squash the next instruction |

## Verification
Some rules are checked by assertions on every clock cycle:
- `skipReq` never lasts two cycles in a row, and it only follows a bit test.
- A squashed cycle produces no write strobes.
- The zero flag holds unless a clear or invert strobe fires.
- Clear-working always leaves zero with the flag set.
- An invert into the working register always yields the inverse of the previous source value.

Other rules can only be shown by the bench's scenarios:
- Which file entry an operation actually lands in.
- That one entry survives while another is written.
- The back-to-back skip patterns, where a second bit test gets squashed, or fires only once the first skip has ended.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_CLRW = 3'd1,
    OP_CLRF = 3'd2,
    OP_COMF = 3'd3,
    OP_BTSS = 3'd4
  } opKind_e;

  typedef struct packed {
    logic clrW;
    logic clrF;
    logic compW;
    logic compF;
    logic zeroWr;
  } ctrlStrobes_t;

endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   opCode,
  input  logic         destSel,
  input  logic         testBit,
  output ctrlStrobes_t strobes,
  output logic         skipReq
);

  logic squash;
  logic skipNext;

  assign squash = skipReq;

  always_comb begin
    strobes  = '0;
    skipNext = 1'b0;
    if (!squash) begin
      case (opKind_e'(opCode))
        OP_CLRW: begin
          strobes.clrW   = 1'b1;
          strobes.zeroWr = 1'b1;
        end
        OP_CLRF: begin
          strobes.clrF   = 1'b1;
          strobes.zeroWr = 1'b1;
        end
        OP_COMF: begin
          strobes.compW  = !destSel;
          strobes.compF  = destSel;
          strobes.zeroWr = 1'b1;
        end
        OP_BTSS: skipNext = testBit;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) skipReq <= 1'b0;
    else     skipReq <= skipNext;
  end

  // R7
  skip_single_chk: assert property (@(posedge clk) disable iff (rst)
    skipReq |=> !skipReq);

  // R9
  squash_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    skipReq |-> (strobes == '0));

endmodule

// File: rtl/acc_dpath.sv
module acc_dpath
  import acc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] fileAddr,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] wOut,
  output logic              zeroFlag,
  output logic              testBit
);

  logic [DATA_W-1:0] fileMem [DEPTH];
  logic [DATA_W-1:0] srcVal;
  logic [DATA_W-1:0] compVal;
  logic              fileWr;
  logic [DATA_W-1:0] fileWrData;

  assign srcVal     = fileMem[fileAddr];
  assign compVal    = ~srcVal;
  assign testBit    = srcVal[bitIdx];
  assign fileWr     = strobes.clrF | strobes.compF;
  assign fileWrData = strobes.clrF ? '0 : compVal;
  assign rdData     = fileMem[rdAddr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)
        fileMem[i] <= '0;
      else if (fileWr && fileAddr == ADDR_W'(i))
        fileMem[i] <= fileWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                wOut <= '0;
    else if (strobes.clrW)  wOut <= '0;
    else if (strobes.compW) wOut <= compVal;
  end

  always_ff @(posedge clk) begin
    if (rst)
      zeroFlag <= 1'b0;
    else if (strobes.zeroWr)
      zeroFlag <= (strobes.clrW | strobes.clrF) ? 1'b1 : (compVal == '0);
  end

  // R2
  clrw_zero_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.clrW |=> (wOut == '0 && zeroFlag));

  // R4
  compw_value_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.compW |=> (wOut == ~$past(srcVal)));

  // R6
  comp_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.compW || strobes.compF) |=> (zeroFlag == ($past(srcVal) == {DATA_W{1'b1}})));

  // R10
  zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.zeroWr |=> $stable(zeroFlag));

endmodule

// File: rtl/acc_exec.sv
module acc_exec
  import acc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        opCode,
  input  logic [ADDR_W-1:0] fileAddr,
  input  logic              destSel,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] wOut,
  output logic              zeroFlag,
  output logic              skipReq
);

  ctrlStrobes_t strobes;
  logic         testBit;

  acc_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .opCode  (opCode),
    .destSel (destSel),
    .testBit (testBit),
    .strobes (strobes),
    .skipReq (skipReq)
  );

  acc_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dpath_i (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .fileAddr (fileAddr),
    .bitIdx   (bitIdx),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .wOut     (wOut),
    .zeroFlag (zeroFlag),
    .testBit  (testBit)
  );

  // R7
  skip_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(skipReq) |-> ($past(opCode) == OP_BTSS));

endmodule

// File: tb/acc_exec_tb_top.sv
module acc_exec_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] opCode;
  logic [4:0] fileAddr;
  logic       destSel;
  logic [2:0] bitIdx;
  logic [4:0] rdAddr;
  logic [7:0] rdData;
  logic [7:0] wOut;
  logic       zeroFlag;
  logic       skipReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  acc_exec dut_i (
    .clk(clk), .rst(rst), .opCode(opCode), .fileAddr(fileAddr),
    .destSel(destSel), .bitIdx(bitIdx), .rdAddr(rdAddr), .rdData(rdData),
    .wOut(wOut), .zeroFlag(zeroFlag), .skipReq(skipReq)
  );

  typedef struct {
    logic [7:0] w;
    logic       z;
    logic       s;
    logic [7:0] f;
    string      tag;
  } exp_t;

  exp_t expQ[$];

  logic [7:0] mW;
  logic [7:0] mFile [32];
  logic       mZ;
  logic       mSkip;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input int a, input logic d, input int b,
                       input string tag);
    exp_t e;
    logic [7:0] r;
    logic nxt;
    @(negedge clk);
    opCode = op; fileAddr = 5'(a); destSel = d; bitIdx = 3'(b); rdAddr = 5'(a);
    nxt = 1'b0;
    if (!mSkip) begin
      case (op)
        3'd1: begin mW = 8'h00; mZ = 1'b1; end
        3'd2: begin mFile[a] = 8'h00; mZ = 1'b1; end
        3'd3: begin
          r = ~mFile[a];
          mZ = (r == 8'h00);
          if (d) mFile[a] = r; else mW = r;
        end
        3'd4: nxt = mFile[a][b];
        default: ;
      endcase
    end
    mSkip = nxt;
    e.w = mW; e.z = mZ; e.s = mSkip; e.f = mFile[a]; e.tag = tag;
    expQ.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        check(e.tag, "wOut", int'(wOut), int'(e.w));
        check(e.tag, "zeroFlag", int'(zeroFlag), int'(e.z));
        check(e.tag, "skipReq", int'(skipReq), int'(e.s));
        check(e.tag, "rdData", int'(rdData), int'(e.f));
      end
    end
  end

  initial begin : watchdog
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    rst = 1'b1; opCode = 3'd0; fileAddr = '0; destSel = 1'b0; bitIdx = '0; rdAddr = '0;
    mW = 8'h00; mZ = 1'b0; mSkip = 1'b0;
    for (int i = 0; i < 32; i++) mFile[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the ports
    check("R1", "wOut", int'(wOut), 0);
    check("R1", "zeroFlag", int'(zeroFlag), 0);
    check("R1", "skipReq", int'(skipReq), 0);
    for (int i = 0; i < 32; i++) begin
      rdAddr = 5'(i);
      #0.1;
      check("R1", "file entry", int'(rdData), 0);
    end

    issue(3'd4, 3, 0, 2, "R8 test zero bit");
    issue(3'd0, 3, 0, 0, "R10 nop not squashed");
    issue(3'd3, 3, 1, 0, "R5 R6 invert to file");
    issue(3'd3, 5, 0, 0, "R4 invert to working");
    issue(3'd4, 3, 0, 7, "R7 test set bit");
    issue(3'd3, 3, 1, 0, "R9 squashed invert");
    issue(3'd1, 0, 0, 0, "R2 clear working");
    issue(3'd3, 3, 0, 0, "R6 invert of FF to working");
    issue(3'd4, 3, 0, 0, "R7 skip first");
    issue(3'd2, 3, 0, 0, "R9 squashed clear file");
    issue(3'd4, 3, 0, 1, "R7 skip after skip ended");
    issue(3'd1, 0, 0, 0, "R9 squashed clear working");
    issue(3'd4, 3, 0, 5, "R7 skip source");
    issue(3'd4, 3, 0, 5, "R9 squashed bit test");
    issue(3'd4, 3, 0, 5, "R10 bit test keeps flags");
    issue(3'd0, 3, 0, 0, "R9 after skip");
    issue(3'd3, 9, 0, 0, "R4 load working FF");
    issue(3'd2, 3, 0, 0, "R3 clear file keeps working");
    issue(3'd5, 3, 1, 0, "R11 code 5");
    issue(3'd6, 9, 1, 0, "R11 code 6");
    issue(3'd7, 9, 1, 0, "R11 code 7");
    issue(3'd3, 31, 1, 0, "R5 top entry");
    issue(3'd3, 0, 1, 0, "R5 bottom entry");
    issue(3'd0, 31, 0, 0, "R10 top entry kept");
    issue(3'd2, 31, 0, 0, "R3 clear top entry");
    issue(3'd0, 0, 0, 0, "R3 other entry kept");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule